// File: doc/BRIEF.md
# Software Trigger Source Combiner

This block produces the trigger requests that software can make without any detector hits. It has three sources. The first is a one-shot trigger caused by a control write. The second is a pseudo-random trigger whose average rate is a programmable fraction of the clock. The third is a periodic trigger whose period is a programmable number of clock cycles. The three requests are combined into one registered trigger pulse stream for the downstream trigger logic.

The random source compares a free-running maximal-length linear feedback shift register (LFSR) with the rate value on every cycle. A rate of zero turns the source off. A full-scale rate makes it fire on almost every cycle. The periodic source counts cycles while it is enabled and fires once each time the count completes. Removing the enable clears the count. Deadtime, prescaling and event assembly are handled by other blocks.

Top module: `soft_trig_gen`

## Requirements
- R1: While `rst_n` is low on a clock edge, `trig_o` is low after that edge, and the periodic counter is cleared.
- R2: A rising edge on `force_wr` makes `trig_o` high for exactly one cycle, starting at the edge where the write is first sampled. Holding `force_wr` high produces no further triggers.
- R3: When `rand_rate` is 0 the random source never fires.
- R4: For a nonzero `rand_rate`, the random source fires on a fraction of cycles close to `rand_rate`/2^32. A rate of 0xFFFFFFFF fires on almost every cycle.
- R5: Take the first clock edge at which `cyc_en` is sampled high as edge 0. If `cyc_interval` = N ≥ 1 and the enable stays high, `trig_o` is high after edges N-1, 2N-1, 3N-1, and so on, and low after every other edge.
- R6: With `cyc_en` high and `cyc_interval` = 0, the periodic source never fires.
- R7: When `cyc_en` is sampled low, the periodic counter returns to zero. Re-enabling then waits a full N cycles before the next trigger, whatever count had been reached before.
- R8: `trig_o` is the registered OR of the three sources. Requests from several sources in the same cycle give one high cycle, not several.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_wr | input | 1 | Force-trigger write strobe; acts on its rising edge |
| rand_rate | input | 32 | Random trigger rate as a fraction of 2^32 |
| cyc_en | input | 1 | Enable for the periodic source |
| cyc_interval | input | 32 | Period of the periodic source, in clock cycles |
| trig_o | output | 1 | Combined trigger pulse, one cycle per trigger |

## Verification
If the periodic counter were corrupted, the phase of the trigger pattern would be wrong within one interval of enabling. The bench would see this at the first expected pulse, because it sweeps every small interval and checks every cycle. A faulty force edge detector shows up within one or two cycles, either as a missing pulse or as repeated pulses while the strobe is held. An LFSR stuck in a bad state or a wrong comparison makes the fraction of random firings drift far from the set rate over a few thousand cycles.

// File: rtl/stg_pkg.sv
// Shared widths and defaults for the software trigger source combiner.
package stg_pkg;
    localparam int unsigned STG_RATE_W  = 32;
    localparam int unsigned STG_CNT_W   = 32;
    localparam logic [31:0] STG_TAPS    = 32'h8020_0003;
    localparam logic [31:0] STG_SEED    = 32'h1D2C_3B4A;

    // One request bit per source, merged in the top module.
    typedef struct packed {
        logic force_req;
        logic rand_req;
        logic cyc_req;
    } stg_req_t;
endpackage

// File: rtl/stg_force_pulse.sv
// Turns the force-trigger write strobe into a single-cycle request.
// Assumes force_wr is synchronous to clk. A strobe held high for several
// cycles counts as one write.
module stg_force_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic force_wr,
    output logic pulse_o
);
    logic wr_q;

    // Remember the strobe level so that only its rising edge gives a request.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= force_wr;
    end

    assign pulse_o = force_wr & ~wr_q;

    // R2
    force_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/stg_rand_src.sv
// Pseudo-random trigger source. A free-running Galois LFSR is compared with
// the rate value; a request is raised when the LFSR is below the rate.
// Assumes TAPS describes a maximal-length polynomial and SEED is nonzero.
module stg_rand_src #(
    parameter int unsigned    W    = 32,
    parameter logic [W-1:0]   TAPS = stg_pkg::STG_TAPS,
    parameter logic [W-1:0]   SEED = stg_pkg::STG_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rate,
    output logic         hit_o
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] lfsr_q;
    logic [W-1:0] lfsr_d;

    // Next state: shift right and fold in the taps when the output bit is set.
    always_comb begin
        lfsr_d = {1'b0, lfsr_q[W-1:1]};
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
    end

    // LFSR state register; it advances on every cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign hit_o = (lfsr_q < rate);

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != ZERO);
endmodule

// File: rtl/stg_cyclic_src.sv
// Periodic trigger source. While enabled with a nonzero interval N it raises
// one request every N cycles. The counter is cleared while disabled, so the
// first request comes N cycles after enabling. If the interval is lowered
// below the current count, the counter wraps at the next cycle.
module stg_cyclic_src #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] interval,
    output logic         hit_o
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q;
    logic         armed;

    assign armed = en && (interval != ZERO);
    assign hit_o = armed && (cnt_q >= interval - ONE);

    // Interval counter: cleared when disabled, restarted after each request.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= ZERO;
        else if (!en)   cnt_q <= ZERO;
        else if (hit_o) cnt_q <= ZERO;
        else if (armed) cnt_q <= cnt_q + ONE;
    end

    // R1
    cyc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> cnt_q == ZERO);
    // R7
    cyc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == ZERO);
    // R5
    cyc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> cnt_q == ZERO);
    // R5
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !hit_o) |=> cnt_q == $past(cnt_q) + ONE);
endmodule

// File: rtl/soft_trig_gen.sv
// Software trigger source combiner. Merges the force, random and periodic
// requests into one registered trigger pulse. Assumes every input is
// synchronous to clk. The reset is synchronous and active low.
module soft_trig_gen #(
    parameter int unsigned          RATE_W = stg_pkg::STG_RATE_W,
    parameter int unsigned          CNT_W  = stg_pkg::STG_CNT_W,
    parameter logic [RATE_W-1:0]    TAPS   = stg_pkg::STG_TAPS,
    parameter logic [RATE_W-1:0]    SEED   = stg_pkg::STG_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_wr,
    input  logic [RATE_W-1:0] rand_rate,
    input  logic              cyc_en,
    input  logic [CNT_W-1:0]  cyc_interval,
    output logic              trig_o
);
    stg_pkg::stg_req_t req;

    stg_force_pulse u_force (
        .clk     (clk),
        .rst_n   (rst_n),
        .force_wr(force_wr),
        .pulse_o (req.force_req)
    );

    stg_rand_src #(.W(RATE_W), .TAPS(TAPS), .SEED(SEED)) u_rand (
        .clk  (clk),
        .rst_n(rst_n),
        .rate (rand_rate),
        .hit_o(req.rand_req)
    );

    stg_cyclic_src #(.W(CNT_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cyc_en),
        .interval(cyc_interval),
        .hit_o   (req.cyc_req)
    );

    // Output register: one high cycle for any set of requests in a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= |req;
    end

    // R1
    trig_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !trig_o);
    // R2
    trig_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wr && !$past(force_wr)) |=> trig_o);
    // R3
    trig_rate0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rand_rate == '0 && !cyc_en && !force_wr) |=> !trig_o);
    // R6
    trig_int0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rand_rate == '0 && cyc_interval == '0 && !force_wr) |=> !trig_o);
endmodule

// File: tb/tb_soft_trig_gen.sv
`timescale 1ns/1ps
module tb_soft_trig_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        force_wr;
    logic [31:0] rand_rate;
    logic        cyc_en;
    logic [31:0] cyc_interval;
    logic        trig_o;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    soft_trig_gen dut (
        .clk(clk), .rst_n(rst_n), .force_wr(force_wr), .rand_rate(rand_rate),
        .cyc_en(cyc_en), .cyc_interval(cyc_interval), .trig_o(trig_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_o=%0b expected %0b at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_vec++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // Tick one cycle: inputs already set, sample after the edge.
    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Periodic pattern over ncyc cycles for interval iv (R5, R6).
    task automatic run_cyc(input int iv, input int ncyc, input string req);
        cyc_interval = iv;
        cyc_en = 1'b1;
        for (int j = 0; j < ncyc; j++) begin
            tick();
            check(req, trig_o, (iv != 0) && (((j + 1) % iv) == 0));
        end
        cyc_en = 1'b0;
        tick();
        check(req, trig_o, 1'b0);
    endtask

    // Count random firings over n cycles (R3, R4).
    task automatic count_rand(input logic [31:0] rate, input int n, output int cnt);
        rand_rate = rate;
        tick();
        cnt = 0;
        for (int j = 0; j < n; j++) begin
            tick();
            if (trig_o) cnt++;
        end
        rand_rate = '0;
        tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            report();
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0; force_wr = 1'b0; rand_rate = '0; cyc_en = 1'b0; cyc_interval = '0;
        @(negedge clk);
        tick();
        // R1: reset state
        check("R1", trig_o, 1'b0);
        // R1: cyclic enabled during reset must not advance the counter
        cyc_interval = 3; cyc_en = 1'b1;
        tick(); tick();
        check("R1", trig_o, 1'b0);
        rst_n = 1'b1;
        for (int j = 0; j < 6; j++) begin
            tick();
            check("R1", trig_o, ((j + 1) % 3) == 0);
        end
        cyc_en = 1'b0;
        tick();

        // R2: rising edge gives one pulse, holding gives no more
        for (int k = 0; k < 3; k++) begin
            force_wr = 1'b1;
            tick();
            check("R2", trig_o, 1'b1);
            for (int j = 0; j < k + 2; j++) begin
                tick();
                check("R2", trig_o, 1'b0);
            end
            force_wr = 1'b0;
            tick();
            check("R2", trig_o, 1'b0);
        end

        // R5: sweep intervals 1..12
        for (int iv = 1; iv <= 12; iv++) run_cyc(iv, 3 * iv + 5, "R5");
        // R6: zero interval never fires
        run_cyc(0, 50, "R6");

        // R7: partial count discarded by disable
        cyc_interval = 5; cyc_en = 1'b1;
        for (int j = 0; j < 3; j++) begin
            tick();
            check("R7", trig_o, 1'b0);
        end
        cyc_en = 1'b0;
        tick(); check("R7", trig_o, 1'b0);
        tick(); check("R7", trig_o, 1'b0);
        run_cyc(5, 16, "R7");

        // R8: force coinciding with a periodic pulse, and one in between
        cyc_interval = 4; cyc_en = 1'b1;
        for (int j = 0; j < 12; j++) begin
            force_wr = (j == 3) || (j == 5);
            tick();
            check("R8", trig_o, (((j + 1) % 4) == 0) || (j == 5));
        end
        force_wr = 1'b0; cyc_en = 1'b0;
        tick();
        // R8: interval 1 merged with force stays high without gaps
        cyc_interval = 1; cyc_en = 1'b1;
        for (int j = 0; j < 6; j++) begin
            force_wr = (j == 2);
            tick();
            check("R8", trig_o, 1'b1);
        end
        force_wr = 1'b0; cyc_en = 1'b0;
        tick();
        check("R8", trig_o, 1'b0);

        // R3: rate 0 silent
        count_rand(32'h0, 3000, cnt);
        check_range("R3", cnt, 0, 0);
        // R4: average rates
        count_rand(32'h8000_0000, 4000, cnt);
        check_range("R4", cnt, 1600, 2400);
        count_rand(32'h4000_0000, 4000, cnt);
        check_range("R4", cnt, 700, 1300);
        count_rand(32'h1000_0000, 8000, cnt);
        check_range("R4", cnt, 250, 750);
        count_rand(32'hFFFF_FFFF, 4000, cnt);
        check_range("R4", cnt, 3990, 4000);

        done = 1'b1;
        report();
    end
endmodule